// File: doc/BRIEF.md
# Daisy-Chain Memory Buffer Frame Node

This block is one node in a point-to-point chain of memory buffers, one per memory module. A frame moves in each direction every frame period (one clock). Frames heading away from the controller (southbound) carry commands or write data. The node passes every southbound frame on to the next node, checks its CRC, and acts only on frames that carry its own node ID and a good CRC.

Frames heading back toward the controller (northbound) come from nodes further down the chain. The node passes them on unchanged and never checks them. The node's own responses (read data and sync status) are generated with a fresh CRC. They are placed only into northbound periods where the downstream input is idle, so downstream traffic is never delayed or dropped.

The DRAM behind the node is modelled as a small word-addressed store with a fixed, parameterised response latency.

Frame layout (85 bits):
- bits [84:82]: node ID
- bits [81:80]: frame type
- bits [79:16]: payload
- bits [15:0]: CRC

Top module: `mbuf_node`

## Requirements
- R1: Every southbound input frame appears unchanged on `sb_frame_o` one frame period later, whatever its ID, type or CRC.
- R2: Every non-idle northbound input frame appears unchanged on `nb_frame_o` one frame period later. Its CRC is not checked and it is never held back.
- R3: The type field uses these codes: 00 idle, 01 command, 10 data, 11 sync. The CRC is computed as follows:
  - polynomial 0x1021, initial value 0xFFFF;
  - processed most significant bit first;
  - computed over the 69 bits {ID, type, payload}.
  A non-idle southbound frame whose CRC does not match is not executed.
- R4: A southbound frame is executed only when all three hold: it is not idle, its CRC is good, and its ID field equals `node_id_i`.
- R5: In a command frame, payload bits [63:62] give the operation: 01 read, 10 write setup. Payload bits [AW-1:0] give the word address. A data frame that follows a write setup stores its 64-bit payload at the latched address and clears the setup. A data frame with no pending setup is ignored.
- R6: A read command accepted in period k produces a response that can leave on `nb_frame_o` from period k+RD_LAT+1 onward. The response has:
  - type data;
  - ID `node_id_i`;
  - the stored word as payload;
  - a freshly computed CRC.
- R7: Local responses are sent in the order they were produced, and only in periods whose northbound input is idle. When no response is waiting, the idle input frame is passed through unchanged.
- R8: Any non-idle southbound frame with a bad CRC sets a sticky error flag. A sync frame addressed to the node produces a sync-type response after the read latency. Its payload bit 0 holds the flag at the moment the response is formed, and all other payload bits are zero. Reporting clears the flag, unless a new CRC error arrives in that same period.
- R9: During reset both outputs are all zero, the store reads as zero, the flag is clear and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Frame clock, one frame per cycle per direction |
| rst_ni | input | 1 | Asynchronous active-low reset |
| node_id_i | input | 3 | This node's position ID |
| sb_frame_i | input | 85 | Southbound frame from upstream |
| sb_frame_o | output | 85 | Southbound frame to downstream |
| nb_frame_i | input | 85 | Northbound frame from downstream |
| nb_frame_o | output | 85 | Northbound frame to upstream |

## Verification
Two pairs of events can fall in the same cycle.
- A local response becoming ready can coincide with busy northbound traffic from downstream. The bench keeps the downstream input busy across a response's ready period and expects the response to appear in the first idle period after, with the busy frames (including ones with corrupt CRCs) passed through untouched.
- A CRC error can arrive in the very period a sync report is formed. The bench expects that report to carry the old flag value while the new error keeps the flag set for the next report.

A per-cycle behavioural model compares both outputs on every clock.

// File: rtl/mbn_pkg.sv
package mbn_pkg;
  localparam int ID_W    = 3;
  localparam int TYP_W   = 2;
  localparam int PAY_W   = 64;
  localparam int CRC_W   = 16;
  localparam int HDR_W   = ID_W + TYP_W + PAY_W;
  localparam int FRAME_W = HDR_W + CRC_W;

  typedef enum logic [TYP_W-1:0] {
    FT_IDLE = 2'b00,
    FT_CMD  = 2'b01,
    FT_DATA = 2'b10,
    FT_SYNC = 2'b11
  } ftype_e;

  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_READ = 2'b01,
    OP_WSET = 2'b10,
    OP_RSV  = 2'b11
  } op_e;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    ftype_e           typ;
    logic [PAY_W-1:0] pay;
    logic [CRC_W-1:0] crc;
  } frame_t;

  function automatic logic [CRC_W-1:0] crc16(input logic [HDR_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '1;
    for (int i = HDR_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction
endpackage

// File: rtl/mbn_sb_rx.sv
module mbn_sb_rx
  import mbn_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ID_W-1:0] node_id_i,
  input  frame_t          frame_i,
  output frame_t          frame_o,
  output logic            hit_o,
  output logic            crc_bad_o
);
  logic live;

  assign live      = frame_i.typ != FT_IDLE;
  assign crc_bad_o = live && (crc16({frame_i.id, frame_i.typ, frame_i.pay}) != frame_i.crc);
  assign hit_o     = live && !crc_bad_o && (frame_i.id == node_id_i);

  // unconditional forward
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_o <= '0;
    else         frame_o <= frame_i;
  end
endmodule

// File: rtl/mbn_rsp_pipe.sv
module mbn_rsp_pipe
  import mbn_pkg::*;
#(
  parameter int AW     = 4,
  parameter int RD_LAT = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ID_W-1:0] node_id_i,
  input  logic            hit_i,
  input  logic            crc_bad_i,
  input  ftype_e          typ_i,
  input  logic [PAY_W-1:0] pay_i,
  output logic            push_o,
  output frame_t          push_frame_o
);
  localparam int WORDS = 1 << AW;

  typedef struct packed {
    logic          v;
    logic          sync;
    logic [AW-1:0] addr;
  } slot_t;

  logic [PAY_W-1:0] mem_q [WORDS];
  slot_t            pipe_q [RD_LAT];
  slot_t            ent, tail;
  logic             arm_q, err_q;
  logic [AW-1:0]    waddr_q;
  op_e              op;
  logic [PAY_W-1:0] rsp_pay;
  ftype_e           rsp_typ;

  assign op       = op_e'(pay_i[PAY_W-1 -: 2]);
  assign ent.v    = hit_i && ((typ_i == FT_CMD && op == OP_READ) || typ_i == FT_SYNC);
  assign ent.sync = typ_i == FT_SYNC;
  assign ent.addr = pay_i[AW-1:0];
  assign tail     = pipe_q[RD_LAT-1];

  // fixed-latency delay line
  for (genvar g = 0; g < RD_LAT; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[g] <= '0;
      else if (g == 0) pipe_q[g] <= ent;
      else pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
    end
  end

  // store stub and write-setup latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
      arm_q   <= 1'b0;
      waddr_q <= '0;
    end else if (hit_i) begin
      if (typ_i == FT_CMD && op == OP_WSET) begin
        arm_q   <= 1'b1;
        waddr_q <= pay_i[AW-1:0];
      end else if (typ_i == FT_DATA && arm_q) begin
        mem_q[waddr_q] <= pay_i;
        arm_q          <= 1'b0;
      end
    end
  end

  // sticky error: new error wins over clear-on-report
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                err_q <= 1'b0;
    else if (crc_bad_i)         err_q <= 1'b1;
    else if (tail.v && tail.sync) err_q <= 1'b0;
  end

  assign rsp_pay = tail.sync ? {{(PAY_W-1){1'b0}}, err_q} : mem_q[tail.addr];
  assign rsp_typ = tail.sync ? FT_SYNC : FT_DATA;

  assign push_o           = tail.v;
  assign push_frame_o.id  = node_id_i;
  assign push_frame_o.typ = rsp_typ;
  assign push_frame_o.pay = rsp_pay;
  assign push_frame_o.crc = crc16({node_id_i, rsp_typ, rsp_pay});
endmodule

// File: rtl/mbn_nb_merge.sv
module mbn_nb_merge
  import mbn_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   push_i,
  input  frame_t push_frame_i,
  input  frame_t frame_i,
  output frame_t frame_o,
  output logic   full_o,
  output logic   pop_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  frame_t        buf_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [PW:0]   cnt_q;
  logic          take;

  assign full_o = cnt_q == (PW+1)'(DEPTH);
  assign pop_o  = (frame_i.typ == FT_IDLE) && (cnt_q != '0);
  assign take   = push_i && (!full_o || pop_o);

  always_ff @(posedge clk_i) begin
    if (take) buf_q[wr_q] <= push_frame_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      wr_q    <= '0;
      cnt_q   <= '0;
      frame_o <= '0;
    end else begin
      if (take)  wr_q <= wr_q + 1'b1;
      if (pop_o) rd_q <= rd_q + 1'b1;
      cnt_q   <= cnt_q + (PW+1)'(take) - (PW+1)'(pop_o);
      // downstream traffic always has the slot
      frame_o <= pop_o ? buf_q[rd_q] : frame_i;
    end
  end
endmodule

// File: rtl/mbuf_node.sv
module mbuf_node
  import mbn_pkg::*;
#(
  parameter int AW        = 4,
  parameter int RD_LAT    = 4,
  parameter int RSP_DEPTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ID_W-1:0]    node_id_i,
  input  logic [FRAME_W-1:0] sb_frame_i,
  output logic [FRAME_W-1:0] sb_frame_o,
  input  logic [FRAME_W-1:0] nb_frame_i,
  output logic [FRAME_W-1:0] nb_frame_o
);
  frame_t sb_in, sb_fwd, nb_in, nb_out, rsp_frame;
  logic   sb_hit, sb_bad, rsp_push, rsp_full, rsp_pop;

  assign sb_in      = frame_t'(sb_frame_i);
  assign nb_in      = frame_t'(nb_frame_i);
  assign sb_frame_o = sb_fwd;
  assign nb_frame_o = nb_out;

  mbn_sb_rx u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .node_id_i (node_id_i),
    .frame_i   (sb_in),
    .frame_o   (sb_fwd),
    .hit_o     (sb_hit),
    .crc_bad_o (sb_bad)
  );

  mbn_rsp_pipe #(.AW(AW), .RD_LAT(RD_LAT)) u_rsp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .node_id_i    (node_id_i),
    .hit_i        (sb_hit),
    .crc_bad_i    (sb_bad),
    .typ_i        (sb_in.typ),
    .pay_i        (sb_in.pay),
    .push_o       (rsp_push),
    .push_frame_o (rsp_frame)
  );

  mbn_nb_merge #(.DEPTH(RSP_DEPTH)) u_nb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (rsp_push),
    .push_frame_i (rsp_frame),
    .frame_i      (nb_in),
    .frame_o      (nb_out),
    .full_o       (rsp_full),
    .pop_o        (rsp_pop)
  );
endmodule

// File: rtl/mbn_node_chk.sv
module mbn_node_chk
  import mbn_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ID_W-1:0]    node_id_i,
  input logic [FRAME_W-1:0] sb_frame_i,
  input logic [FRAME_W-1:0] sb_frame_o,
  input logic [FRAME_W-1:0] nb_frame_i,
  input logic [FRAME_W-1:0] nb_frame_o,
  input logic               push,
  input logic               full,
  input logic               pop
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R1
  sb_forward_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    sb_frame_o == $past(sb_frame_i));

  // R2
  nb_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (nb_frame_i[81:80] != 2'b00) |=> (nb_frame_o == $past(nb_frame_i)));

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push && full && !pop));

  // R6
  local_crc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> (nb_frame_o[15:0] == crc16(nb_frame_o[84:16])) && (nb_frame_o[84:82] == $past(node_id_i)));

  // R8
  sync_payload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> (nb_frame_o[81:80] != 2'b11) || (nb_frame_o[79:17] == '0));
endmodule

bind mbuf_node mbn_node_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .node_id_i  (node_id_i),
  .sb_frame_i (sb_frame_i),
  .sb_frame_o (sb_frame_o),
  .nb_frame_i (nb_frame_i),
  .nb_frame_o (nb_frame_o),
  .push       (rsp_push),
  .full       (rsp_full),
  .pop        (rsp_pop)
);

// File: tb/sim_mbuf_node.sv
`timescale 1ns/1ps
module sim_mbuf_node;
  localparam int RD_LAT = 4;
  localparam logic [2:0] NODE  = 3'd5;
  localparam logic [2:0] OTHER = 3'd2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [84:0] sb_i = '0, nb_i = '0;
  logic [84:0] sb_o, nb_o;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // reference state
  logic [63:0] mem_m [16];
  bit          arm_m = 0, err_m = 0;
  int          waddr_m = 0;
  int          mat_q[$];
  bit          syn_q[$];
  int          adr_q[$];
  logic [84:0] rq[$];
  logic [84:0] exp_sb = '0, exp_nb = '0;

  always #2.5 clk = ~clk;

  mbuf_node u0 (
    .clk_i(clk), .rst_ni(rst_ni), .node_id_i(NODE),
    .sb_frame_i(sb_i), .sb_frame_o(sb_o),
    .nb_frame_i(nb_i), .nb_frame_o(nb_o)
  );

  function automatic logic [15:0] ref_crc(input logic [68:0] d);
    logic [15:0] r = 16'hFFFF;
    for (int i = 68; i >= 0; i--) begin
      if (r[15] != d[i]) r = (r << 1) ^ 16'h1021;
      else               r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [84:0] mk(input logic [2:0] id, input logic [1:0] t, input logic [63:0] p);
    return {id, t, p, ref_crc({id, t, p})};
  endfunction

  function automatic logic [63:0] cmd(input logic [1:0] op, input int a);
    return {op, 58'd0, 4'(a)};
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic chk(input string tag, input logic [84:0] got, input logic [84:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d got %h exp %h", tag, cyc, got, exp);
    end
  endtask

  task automatic step(input string tag, input logic [84:0] sb, input logic [84:0] nb);
    logic [63:0] p;
    logic [1:0]  t;
    sb_i = sb; nb_i = nb;
    @(posedge clk); #1;
    cyc++;
    exp_sb = sb;
    if (nb[81:80] != 2'b00)  exp_nb = nb;
    else if (rq.size() > 0)  exp_nb = rq.pop_front();
    else                     exp_nb = nb;
    if (mat_q.size() > 0 && mat_q[0] == cyc) begin
      void'(mat_q.pop_front());
      if (syn_q.pop_front()) begin
        rq.push_back(mk(NODE, 2'b11, {63'd0, err_m}));
        err_m = 0;
        void'(adr_q.pop_front());
      end else begin
        rq.push_back(mk(NODE, 2'b10, mem_m[adr_q.pop_front()]));
      end
    end
    t = sb[81:80];
    p = sb[79:16];
    if (t != 2'b00) begin
      if (ref_crc(sb[84:16]) != sb[15:0]) err_m = 1;
      else if (sb[84:82] == NODE) begin
        if (t == 2'b01 && p[63:62] == 2'b01) begin
          mat_q.push_back(cyc + RD_LAT); syn_q.push_back(0); adr_q.push_back(int'(p[3:0]));
        end else if (t == 2'b01 && p[63:62] == 2'b10) begin
          arm_m = 1; waddr_m = int'(p[3:0]);
        end else if (t == 2'b10 && arm_m) begin
          mem_m[waddr_m] = p; arm_m = 0;
        end else if (t == 2'b11) begin
          mat_q.push_back(cyc + RD_LAT); syn_q.push_back(1); adr_q.push_back(0);
        end
      end
    end
    chk("R1 southbound forward", sb_o, exp_sb);
    chk(tag, nb_o, exp_nb);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, '0, '0);
  endtask

  function automatic logic [84:0] busy();
    logic [95:0] r = {$urandom, $urandom, $urandom};
    if (r[81:80] == 2'b00) r[80] = 1'b1;
    return r[84:0];
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) mem_m[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset sb", sb_o, '0);
    chk("R9 reset nb", nb_o, '0);
    @(negedge clk); rst_ni = 1'b1;

    // R9 store reads zero after reset, flag clear
    step("R9 read after reset", mk(NODE, 2'b01, cmd(2'b01, 2)), '0);
    step("R9 sync after reset", mk(NODE, 2'b11, 64'd0), '0);
    idle("R6 read latency", RD_LAT + 3);

    // R5 write then read back; R4 other-ID writes ignored
    step("R5 wset", mk(NODE, 2'b01, cmd(2'b10, 3)), '0);
    step("R5 data", mk(NODE, 2'b10, 64'hDEAD_BEEF_0123_4567), '0);
    step("R4 other wset", mk(OTHER, 2'b01, cmd(2'b10, 4)), '0);
    step("R4 other data", mk(OTHER, 2'b10, 64'h1111_2222_3333_4444), '0);
    step("R4 other read", mk(OTHER, 2'b01, cmd(2'b01, 3)), '0);
    step("R5 read 3", mk(NODE, 2'b01, cmd(2'b01, 3)), '0);
    step("R4 read 4", mk(NODE, 2'b01, cmd(2'b01, 4)), '0);
    idle("R6 response", RD_LAT + 4);
    // R5 data without setup ignored
    step("R5 lone data", mk(NODE, 2'b10, 64'hFFFF_0000_FFFF_0000), '0);
    step("R5 read 4 again", mk(NODE, 2'b01, cmd(2'b01, 4)), '0);
    idle("R5 response", RD_LAT + 3);

    // R3 corrupt CRC: no execution, flag set
    step("R3 bad wset", mk(NODE, 2'b01, cmd(2'b10, 7)) ^ 85'd1, '0);
    step("R3 data after bad", mk(NODE, 2'b10, 64'h7777), '0);
    step("R3 read 7", mk(NODE, 2'b01, cmd(2'b01, 7)), '0);
    idle("R3 response", RD_LAT + 3);

    // R8 sync reports then clears
    step("R8 sync 1", mk(NODE, 2'b11, 64'd0), '0);
    idle("R8 report", RD_LAT + 2);
    step("R8 sync 2", mk(NODE, 2'b11, 64'd0), '0);
    idle("R8 cleared", RD_LAT + 2);
    // R8 error in the same period as the report
    step("R3 bad frame", mk(OTHER, 2'b10, 64'h5) ^ 85'd2, '0);
    step("R8 sync 3", mk(NODE, 2'b11, 64'd0), '0);
    idle("R8 pre", RD_LAT - 1);
    step("R8 coincident error", mk(OTHER, 2'b01, 64'h9) ^ 85'd4, '0);
    idle("R8 report old", 3);
    step("R8 sync 4", mk(NODE, 2'b11, 64'd0), '0);
    idle("R8 report new", RD_LAT + 2);

    // R7 / R2 contention: downstream busy across response readiness
    step("R7 read", mk(NODE, 2'b01, cmd(2'b01, 3)), '0);
    step("R7 read2", mk(NODE, 2'b01, cmd(2'b01, 0)), busy());
    for (int i = 0; i < 10; i++) step("R2 busy downstream", '0, busy());
    idle("R7 drain", 4);

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [84:0] s, n;
      int k = $urandom_range(0, 9);
      logic [2:0] id = ($urandom_range(0, 2) != 0) ? NODE : 3'($urandom);
      case (k)
        0, 1: s = mk(id, 2'b01, cmd(2'b01, $urandom_range(0, 15)));
        2:    s = mk(id, 2'b01, cmd(2'b10, $urandom_range(0, 15)));
        3, 4: s = mk(id, 2'b10, rnd64());
        5:    s = mk(id, 2'b11, 64'd0);
        6:    s = mk(id, 2'($urandom_range(1, 3)), rnd64()) ^ 85'd8;
        default: s = '0;
      endcase
      n = (rq.size() < 2 && $urandom_range(0, 1) == 1) ? busy() : '0;
      step("R7 mixed", s, n);
    end
    idle("R7 final drain", RD_LAT + 6);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog cycle %0d got hung exp done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule